// File: doc/BRIEF.md
# FM Channel Scan Controller

This block walks a frequency synthesizer across the 100 FM broadcast channels, from 88.1 MHz to 107.9 MHz in 0.2 MHz steps, and looks for one that nobody is using. Channel index `i` is 88.1 MHz + 0.2 MHz × i. The local oscillator sits 10.7 MHz above the channel and passes a fixed divide-by-64 prescaler before it reaches the programmable divider. For each channel the block therefore computes the divider value as an affine function of the index, `DIV_BASE + i × DIV_STEP`, and presents it with a one-cycle load strobe. With the default reference of 3.125 kHz this is 494 + i.

After a load, the controller waits a settle interval so that the loop can lock and the roughly one-second detector smoothing can catch up. It then takes detector samples one dwell interval apart. The channel is accepted only if `HITS` samples in a row are below the threshold. A single loud sample moves the scan to the next channel. The scan wraps from the last channel to channel 0. If a full pass of 100 channels turns up nothing, the scan ends with a fail flag.

The states are ST_IDLE, ST_SET_DIV, ST_SETTLE, ST_SAMPLE, ST_DECIDE and ST_DONE. The transitions are:
- IDLE or DONE → SET_DIV on `start`.
- SET_DIV → SETTLE always.
- SETTLE → SAMPLE when the settle timer expires.
- SAMPLE → DECIDE when the dwell timer expires.
- DECIDE → SAMPLE on a quiet sample while the run is still short.
- DECIDE → DONE on the final quiet sample, or on a loud sample at the end of a pass.
- DECIDE → SET_DIV on a loud sample otherwise.

Top module: `fm_scan_ctrl`

## Requirements
- R1: Each channel visit drives `divisor` = DIV_BASE + index × DIV_STEP (default 494 + index), together with a `div_load` pulse exactly one cycle wide. `divisor` changes only in a cycle where `div_load` is high.
- R2: A `start` pulse begins a scan at `start_idx`. A `start_idx` above 99 begins the scan at channel 0.
- R3: After a load the block waits `settle_cycles`+1 cycles. It then takes each sample after a further `dwell_cycles`+1 cycles.
- R4: A sample is quiet when `level` < `threshold`. A `level` equal to or above `threshold` marks the channel occupied.
- R5: A channel is accepted only after HITS (default 3) consecutive quiet samples. One occupied sample abandons the channel.
- R6: After channel 99 the scan continues at channel 0.
- R7: If 100 consecutive channels are all rejected, the scan stops with `fail`=1 and `done`=0, after exactly 100 loads.
- R8: On acceptance, `done`=1 and `found_idx` holds the channel. Both stay unchanged until the next accepted `start`.
- R9: A `start` that arrives while `busy` is high is ignored.
- R10: After reset, `busy`, `done`, `fail` and `div_load` are 0 and `divisor` equals DIV_BASE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| start | input | 1 | begin a scan (one-cycle pulse) |
| start_idx | input | 7 | first channel to try |
| settle_cycles | input | 24 | settle wait after each load |
| dwell_cycles | input | 24 | wait between samples |
| threshold | input | 10 | occupancy threshold |
| level | input | 10 | digitized smoothed detector level |
| divisor | output | 12 | programmable divider value |
| div_load | output | 1 | one-cycle strobe when divisor is new |
| busy | output | 1 | scan in progress |
| done | output | 1 | free channel found |
| fail | output | 1 | full pass found nothing |
| found_idx | output | 7 | accepted channel index |

## Verification
The assertions check on every cycle the properties that do not depend on the scenario:
- the load strobe is one cycle wide;
- the divisor changes only with the strobe and stays inside the channel range;
- done and fail are exclusive;
- the found index is held and changes only when done rises.

Only the bench's scenarios can show the rest:
- the order in which channels are visited, including wrap-around and out-of-range start points;
- the threshold boundary and the consecutive-sample rule;
- the exact number of loads before success or failure;
- that a start during a scan is ignored.

// File: rtl/fm_scan_pkg.sv
package fm_scan_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SET_DIV,
        ST_SETTLE,
        ST_SAMPLE,
        ST_DECIDE,
        ST_DONE
    } scan_state_e;
endpackage

// File: rtl/fm_interval_timer.sv
// Loadable down-counter used for settle and dwell intervals.
module fm_interval_timer #(
    parameter int TIME_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [TIME_W-1:0] load_val,
    input  logic              dec,
    output logic              expired
);
    logic [TIME_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/fm_chan_stepper.sv
// Holds the current channel index, wraps it, and tracks progress through a pass.
module fm_chan_stepper #(
    parameter int CHAN_COUNT = 100,
    parameter int IDX_W      = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic [IDX_W-1:0] init_idx,
    input  logic             advance,
    output logic [IDX_W-1:0] idx,
    output logic             pass_end
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CHAN_COUNT - 1);

    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] pos_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            pos_q <= '0;
        end else if (init) begin
            idx_q <= (init_idx > LAST_IDX) ? '0 : init_idx;
            pos_q <= '0;
        end else if (advance) begin
            idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
            pos_q <= pos_q + 1'b1;
        end
    end

    assign idx      = idx_q;
    assign pass_end = (pos_q == LAST_IDX);
endmodule

// File: rtl/fm_div_calc.sv
// Computes and registers the divider value for a channel index.
module fm_div_calc #(
    parameter int IDX_W    = 7,
    parameter int DIV_W    = 12,
    parameter int DIV_BASE = 494,
    parameter int DIV_STEP = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [IDX_W-1:0] idx,
    output logic [DIV_W-1:0] divisor,
    output logic             div_load
);
    localparam logic [DIV_W-1:0] BASE_V = DIV_W'(DIV_BASE);
    localparam logic [DIV_W-1:0] STEP_V = DIV_W'(DIV_STEP);

    logic [DIV_W-1:0] next_div;

    always_comb begin
        next_div = BASE_V + DIV_W'(idx) * STEP_V;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            divisor  <= BASE_V;
            div_load <= 1'b0;
        end else begin
            div_load <= go;
            if (go) begin
                divisor <= next_div;
            end
        end
    end
endmodule

// File: rtl/fm_scan_ctrl.sv
module fm_scan_ctrl
    import fm_scan_pkg::*;
#(
    parameter int CHAN_COUNT = 100,
    parameter int DIV_W      = 12,
    parameter int DIV_BASE   = 494,
    parameter int DIV_STEP   = 1,
    parameter int LVL_W      = 10,
    parameter int TIME_W     = 24,
    parameter int HITS       = 3,
    localparam int IDX_W     = $clog2(CHAN_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W-1:0]  start_idx,
    input  logic [TIME_W-1:0] settle_cycles,
    input  logic [TIME_W-1:0] dwell_cycles,
    input  logic [LVL_W-1:0]  threshold,
    input  logic [LVL_W-1:0]  level,
    output logic [DIV_W-1:0]  divisor,
    output logic              div_load,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [IDX_W-1:0]  found_idx
);
    localparam int HIT_W = $clog2(HITS + 1);
    localparam logic [HIT_W-1:0] LAST_HIT = HIT_W'(HITS - 1);

    scan_state_e      st_q, st_nx;
    logic             step_init, step_adv, tmr_load, tmr_dec, div_go;
    logic [TIME_W-1:0] tmr_val;
    logic             tmr_expired, pass_end;
    logic [IDX_W-1:0] chan_idx;
    logic [HIT_W-1:0] hits_q;
    logic             quiet_q;
    logic             accept_start;

    assign accept_start = start && (st_q == ST_IDLE || st_q == ST_DONE);

    fm_chan_stepper #(.CHAN_COUNT(CHAN_COUNT), .IDX_W(IDX_W)) u_step (
        .clk(clk), .rst_n(rst_n), .init(step_init), .init_idx(start_idx),
        .advance(step_adv), .idx(chan_idx), .pass_end(pass_end)
    );

    fm_interval_timer #(.TIME_W(TIME_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .dec(tmr_dec), .expired(tmr_expired)
    );

    fm_div_calc #(.IDX_W(IDX_W), .DIV_W(DIV_W), .DIV_BASE(DIV_BASE),
                  .DIV_STEP(DIV_STEP)) u_div (
        .clk(clk), .rst_n(rst_n), .go(div_go), .idx(chan_idx),
        .divisor(divisor), .div_load(div_load)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_nx;
        end
    end

    // Next state and sub-block controls
    always_comb begin
        st_nx     = st_q;
        step_init = 1'b0;
        step_adv  = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = settle_cycles;
        tmr_dec   = 1'b0;
        div_go    = 1'b0;
        unique case (st_q)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    st_nx     = ST_SET_DIV;
                    step_init = 1'b1;
                end
            end
            ST_SET_DIV: begin
                div_go   = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = settle_cycles;
                st_nx    = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    tmr_val  = dwell_cycles;
                    st_nx    = ST_SAMPLE;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            ST_SAMPLE: begin
                if (tmr_expired) begin
                    st_nx = ST_DECIDE;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            ST_DECIDE: begin
                if (quiet_q) begin
                    if (hits_q == LAST_HIT) begin
                        st_nx = ST_DONE;
                    end else begin
                        tmr_load = 1'b1;
                        tmr_val  = dwell_cycles;
                        st_nx    = ST_SAMPLE;
                    end
                end else if (pass_end) begin
                    st_nx = ST_DONE;
                end else begin
                    step_adv = 1'b1;
                    st_nx    = ST_SET_DIV;
                end
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // Registered outputs and qualification state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done      <= 1'b0;
            fail      <= 1'b0;
            found_idx <= '0;
            hits_q    <= '0;
            quiet_q   <= 1'b0;
        end else begin
            if (accept_start) begin
                done   <= 1'b0;
                fail   <= 1'b0;
                hits_q <= '0;
            end
            if (st_q == ST_SETTLE && tmr_expired) begin
                hits_q <= '0;
            end
            if (st_q == ST_SAMPLE && tmr_expired) begin
                quiet_q <= (level < threshold);
            end
            if (st_q == ST_DECIDE) begin
                if (quiet_q) begin
                    if (hits_q == LAST_HIT) begin
                        done      <= 1'b1;
                        found_idx <= chan_idx;
                    end else begin
                        hits_q <= hits_q + 1'b1;
                    end
                end else if (pass_end) begin
                    fail <= 1'b1;
                end
            end
        end
    end

    assign busy = (st_q != ST_IDLE) && (st_q != ST_DONE);
endmodule

// File: rtl/fm_scan_ctrl_chk.sv
module fm_scan_ctrl_chk #(
    parameter int CHAN_COUNT = 100,
    parameter int DIV_W      = 12,
    parameter int DIV_BASE   = 494,
    parameter int DIV_STEP   = 1,
    parameter int IDX_W      = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [DIV_W-1:0] divisor,
    input logic             div_load,
    input logic             busy,
    input logic             done,
    input logic             fail,
    input logic [IDX_W-1:0] found_idx
);
    localparam int DIV_TOP = DIV_BASE + (CHAN_COUNT - 1) * DIV_STEP;

    a_r1_load_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        div_load |=> !div_load);

    a_r1_div_range: assert property (@(posedge clk) disable iff (!rst_n)
        div_load |-> (int'(divisor) >= DIV_BASE && int'(divisor) <= DIV_TOP));

    a_r1_div_with_load: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(divisor) |-> div_load);

    a_r7_done_fail_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(found_idx)));

    a_r8_found_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(found_idx) |-> $rose(done));

    a_r3_load_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        div_load |-> (busy && !done && !fail));
endmodule

bind fm_scan_ctrl fm_scan_ctrl_chk #(
    .CHAN_COUNT(CHAN_COUNT), .DIV_W(DIV_W), .DIV_BASE(DIV_BASE),
    .DIV_STEP(DIV_STEP), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .divisor(divisor),
    .div_load(div_load), .busy(busy), .done(done), .fail(fail),
    .found_idx(found_idx)
);

// File: tb/fm_scan_ctrl_tb.sv
module fm_scan_ctrl_tb;
    localparam int NCH  = 100;
    localparam int BASE = 494;
    localparam int THR  = 300;
    localparam int SET  = 3;
    localparam int DWL  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [6:0]  start_idx = '0;
    logic [23:0] settle_cycles = 24'(SET);
    logic [23:0] dwell_cycles = 24'(DWL);
    logic [9:0]  threshold = 10'(THR);
    logic [9:0]  level = 10'(THR);
    logic [11:0] divisor;
    logic        div_load, busy, done, fail;
    logic [6:0]  found_idx;

    int n_chk = 0, n_bad = 0;
    int quiet_ch = -1, flaky_ch = -1;
    int exp_ch = 0, loads = 0, since = 0, cyc = 0;

    always #5 clk = ~clk;

    fm_scan_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_idx(start_idx),
        .settle_cycles(settle_cycles), .dwell_cycles(dwell_cycles),
        .threshold(threshold), .level(level), .divisor(divisor),
        .div_load(div_load), .busy(busy), .done(done), .fail(fail),
        .found_idx(found_idx)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int model_level(input int ch, input int t);
        if (ch == quiet_ch) return THR - 1;           // R4: just below is quiet
        if (ch == flaky_ch && t < 8) return THR - 1;  // R5: quiet only for first sample
        return THR;                                    // R4: equal is occupied
    endfunction

    // Channel model and load monitor (R1, R2, R6)
    always @(negedge clk) begin
        cyc++;
        if (div_load) begin
            chk(int'(divisor) == BASE + exp_ch, "R1/R6 divisor", int'(divisor), BASE + exp_ch);
            exp_ch = (exp_ch + 1) % NCH;
            loads++;
            since = 0;
        end else begin
            since++;
        end
        level <= 10'(model_level(int'(divisor) - BASE, since));
        if (cyc > 150000) begin
            chk(1'b0, "watchdog", cyc, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic pulse_start(input int idx, input bit arm);
        @(negedge clk);
        if (arm) begin
            exp_ch = (idx > NCH - 1) ? 0 : idx;
            loads  = 0;
        end
        start     = 1'b1;
        start_idx = 7'(idx);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (done || fail) return;
        end
        chk(1'b0, "watchdog wait", 0, 1);
    endtask

    // start, quiet channel (-1 none), flaky channel, expected loads
    localparam int NV = 7;
    localparam int VEC [NV][4] = '{
        '{10,  15, -1,   6},   // R2 plain
        '{95,   2, -1,   8},   // R6 wrap
        '{0,    0, -1,   1},   // R2 first channel
        '{40,  42, 41,   3},   // R5 flaky rejected
        '{120,  3, -1,   4},   // R2 out of range start
        '{50,  -1, -1, 100},   // R7 no free channel
        '{99,  99, -1,   1}    // R6 last channel
    };

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(!busy && !done && !fail && !div_load, "R10 flags", {busy, done, fail, div_load}, 0);
        chk(int'(divisor) == BASE, "R10 divisor", int'(divisor), BASE);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            quiet_ch = VEC[v][1];
            flaky_ch = VEC[v][2];
            pulse_start(VEC[v][0], 1'b1);
            wait_end();
            @(negedge clk);
            chk(loads == VEC[v][3], "R3/R5/R7 load count", loads, VEC[v][3]);
            if (VEC[v][1] < 0) begin
                chk(fail && !done, "R7 fail flag", {fail, done}, 2);
            end else begin
                chk(done && !fail, "R8 done flag", {done, fail}, 2);
                chk(int'(found_idx) == VEC[v][1], "R8 found_idx", int'(found_idx), VEC[v][1]);
            end
        end

        // R8: result held after done while detector changes
        quiet_ch = 15; flaky_ch = -1;
        pulse_start(10, 1'b1);
        wait_end();
        quiet_ch = 70;
        repeat (20) @(negedge clk);
        chk(done && int'(found_idx) == 15, "R8 hold", int'(found_idx), 15);

        // R9: start during a scan is ignored
        quiet_ch = 30;
        pulse_start(10, 1'b1);
        wait (loads == 3);
        pulse_start(70, 1'b0);
        wait_end();
        @(negedge clk);
        chk(done && int'(found_idx) == 30, "R9 found", int'(found_idx), 30);
        chk(loads == 21, "R9 loads", loads, 21);

        // R3: settle timing, no sample taken before settle+dwell elapse
        settle_cycles = 24'd20;
        quiet_ch = 5;
        pulse_start(5, 1'b1);
        repeat (12) @(negedge clk);
        chk(busy && !done, "R3 still settling", done, 0);
        wait_end();
        chk(done && int'(found_idx) == 5, "R3 found", int'(found_idx), 5);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule